// File: doc/BRIEF.md
# Serial Audio Link Frame Receiver

This block is the codec-side receiver of a 256-bit time-division serial audio link. It samples the frame-sync and serial-data lines on each sampling edge of the bit clock. It aligns itself to the frame start and splits each frame into a 16-bit tag slot and twelve 20-bit data slots, with the most significant bit first. From the tag it takes the frame-valid flag, the per-slot valid flags and the target codec ID.

Slot 1 carries a register command header and slot 2 carries write data. The block applies the acceptance rules that depend on the codec ID. It then issues each accepted command as a one-cycle request carrying a read/write flag, an index and data. Playback slots 3 to 10 are passed on as 20-bit samples, each with its own one-cycle strobe, but only when their valid flag is set. The codec's own ID is a static input. A level input says whether the codec is ready; while it is low, commands are dropped.

`clk_i` is the sampling clock, so it ticks on the falling edge of the link bit clock. Bit positions below count from 0 at the first tag bit. Tag bit 15 is frame valid, bit 14 is slot 1 valid, bit 13 is slot 2 valid, bit 15-k is the valid flag of slot k for k = 3..10, and bits 1:0 are the target ID.

Top module: `ac_link_rx`

## Requirements
- R1: While `rst_ni` is low and after reset, before any frame, `reg_req_o`, `reg_wr_o`, `reg_idx_o`, `reg_wdata_o`, `pcm_stb_o` and `pcm_data_o` are all zero.
- R2: A frame starts when `sync_i` is sampled high after being sampled low. The data bit sampled at that same edge belongs to the previous frame, and the next sample is tag bit 15. No strobe is issued at any position other than the ends of slots 1 to 10.
- R3: When `codec_id_i` is 0, a read is accepted if tag bits 15 and 14 are set, slot 1 bit 19 is 1 and the index (slot 1 bits 18:12) is even. `reg_req_o` then pulses for one cycle with `reg_wr_o`=0 and `reg_idx_o` equal to the index, in the cycle after bit 35 is sampled.
- R4: When `codec_id_i` is 0, a write is accepted if tag bits 15, 14 and 13 are all set, slot 1 bit 19 is 0 and the index is even. `reg_req_o` then pulses with `reg_wr_o`=1 and `reg_wdata_o` equal to slot 2 bits 19:4, in the cycle after bit 55 is sampled. If tag bit 13 is clear, no write is issued. `reg_wdata_o` changes only with a write request.
- R5: When `codec_id_i` is nonzero, an access is accepted only if tag bits 1:0 equal `codec_id_i` and tag bits 14 and 13 are both clear. The timing is the same as in R3 and R4.
- R6: A command with an odd index (slot 1 bit 12 set) issues no request.
- R7: When tag bit 15 is clear, no request and no sample strobe is issued. When `ready_i` is low, no request is issued.
- R8: For slot k in 3..10 with tag bits 15 and 15-k set, `pcm_stb_o[k-3]` pulses for one cycle with `pcm_data_o` equal to the slot's 20 bits, in the cycle after bit 15+20k is sampled. At most one strobe bit is high at a time.
- R9: A playback slot whose valid bit is clear gives no strobe.
- R10: A sync rising part-way through a frame drops the partial frame and realigns, so that the new frame is decoded in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, on the falling edge of the link bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Frame sync |
| sdo_i | input | 1 | Serial data from the controller |
| ready_i | input | 1 | Codec ready level; commands are dropped while it is low |
| codec_id_i | input | 2 | Static own ID, where 0 means primary |
| reg_req_o | output | 1 | One-cycle register request |
| reg_wr_o | output | 1 | 1 = write, 0 = read |
| reg_idx_o | output | 7 | Register index |
| reg_wdata_o | output | 16 | Write data |
| pcm_stb_o | output | 8 | Per-slot sample strobe, where bit 0 is slot 3 |
| pcm_data_o | output | 20 | Sample data |

## Verification
A slot or bit counter that is off by one shifts every decoded field. This shows within the first frame as a wrong index, wrong data, or a strobe at the wrong bit position, because the bench checks the outputs after every sampled bit. A wrong latched tag or a wrong acceptance rule shows as a missing or extra request at bit 35 or bit 55 of the same frame. A sync edge detector that fails to realign shows in the frame that directly follows an aborted one.

// File: rtl/ac_rx_pkg.sv
`timescale 1ns/1ps
package ac_rx_pkg;
  localparam int unsigned TAG_BITS   = 16;
  localparam int unsigned SLOT_BITS  = 20;
  localparam int unsigned DATA_SLOTS = 12;
  localparam int unsigned PCM_LO     = 3;
  localparam int unsigned PCM_HI     = 10;
  localparam int unsigned IDX_BITS   = 7;
  localparam int unsigned WDAT_BITS  = 16;
  localparam int unsigned ID_BITS    = 2;

  typedef enum logic {ROLE_PRIMARY, ROLE_SECONDARY} role_e;
endpackage

// File: rtl/ac_rx_timer.sv
`timescale 1ns/1ps
module ac_rx_timer #(
  parameter int unsigned TAG_W     = 16,
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned NUM_SLOTS = 12,
  localparam int unsigned SIDX_W   = $clog2(NUM_SLOTS + 1),
  localparam int unsigned MAX_W    = (SLOT_W > TAG_W) ? SLOT_W : TAG_W,
  localparam int unsigned CNT_W    = $clog2(MAX_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  output logic              slot_end_o,
  output logic [SIDX_W-1:0] slot_idx_o
);
  logic              sync_q, active_q, last;
  logic [CNT_W-1:0]  bit_q;
  logic [SIDX_W-1:0] slot_q;
  logic              start;

  assign start = sync_i & ~sync_q;

  always_comb begin
    if (slot_q == '0) last = (bit_q == CNT_W'(TAG_W - 1));
    else              last = (bit_q == CNT_W'(SLOT_W - 1));
  end

  assign slot_end_o = active_q & last;
  assign slot_idx_o = slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= 1'b0;
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else begin
      sync_q <= sync_i;
      if (start) begin
        // the bit on this edge closes the old frame; realign here
        active_q <= 1'b1;
        bit_q    <= '0;
        slot_q   <= '0;
      end else if (active_q) begin
        if (last) begin
          bit_q <= '0;
          if (slot_q == SIDX_W'(NUM_SLOTS)) active_q <= 1'b0;
          else                              slot_q   <= slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ac_rx_shift.sv
`timescale 1ns/1ps
module ac_rx_shift #(
  parameter int unsigned SLOT_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdo_i,
  output logic [SLOT_W-1:0] word_o
);
  logic [SLOT_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[SLOT_W-3:0], sdo_i};
  end

  // includes the bit being sampled now, so a slot is whole on its last edge
  assign word_o = {sh_q, sdo_i};
endmodule

// File: rtl/ac_rx_cmd.sv
`timescale 1ns/1ps
module ac_rx_cmd
  import ac_rx_pkg::*;
#(
  parameter int unsigned SIDX_W = 4,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ID_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  input  logic [SIDX_W-1:0] slot_idx_i,
  input  logic [DATA_W-1:0] word_hi_i,
  input  logic [2:0]        tag_flags_i,
  input  logic [ID_W-1:0]   tag_id_i,
  input  logic [ID_W-1:0]   codec_id_i,
  input  logic              ready_i,
  output logic              req_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [DATA_W-1:0] wdata_o
);
  role_e            role;
  logic             fv, v1, v2, id_hit, rd_ok, wr_ok;
  logic             rd_hit, wr_hit, hdr_cap;
  logic             hdr_rd_q;
  logic [IDX_W-1:0] hdr_idx_q;
  logic             w_rd;
  logic [IDX_W-1:0] w_idx;

  assign role   = (codec_id_i == '0) ? ROLE_PRIMARY : ROLE_SECONDARY;
  assign fv     = tag_flags_i[2] & ready_i;
  assign v1     = tag_flags_i[1];
  assign v2     = tag_flags_i[0];
  assign id_hit = (tag_id_i == codec_id_i);
  assign w_rd   = word_hi_i[DATA_W-1];
  assign w_idx  = word_hi_i[DATA_W-2 -: IDX_W];

  always_comb begin
    if (role == ROLE_PRIMARY) begin
      rd_ok = v1;
      wr_ok = v1 & v2;
    end else begin
      rd_ok = id_hit & ~v1 & ~v2;
      wr_ok = id_hit & ~v1 & ~v2;
    end
  end

  assign hdr_cap = slot_end_i & (slot_idx_i == SIDX_W'(1));
  assign rd_hit  = hdr_cap & fv & rd_ok & w_rd & ~w_idx[0];
  assign wr_hit  = slot_end_i & (slot_idx_i == SIDX_W'(2)) & fv & wr_ok
                 & ~hdr_rd_q & ~hdr_idx_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_rd_q  <= 1'b0;
      hdr_idx_q <= '0;
      req_o     <= 1'b0;
      wr_o      <= 1'b0;
      idx_o     <= '0;
      wdata_o   <= '0;
    end else begin
      req_o <= rd_hit | wr_hit;
      if (hdr_cap) begin
        hdr_rd_q  <= w_rd;
        hdr_idx_q <= w_idx;
      end
      if (rd_hit) begin
        wr_o  <= 1'b0;
        idx_o <= w_idx;
      end
      if (wr_hit) begin
        wr_o    <= 1'b1;
        idx_o   <= hdr_idx_q;
        wdata_o <= word_hi_i;
      end
    end
  end
endmodule

// File: rtl/ac_rx_pcm.sv
`timescale 1ns/1ps
module ac_rx_pcm #(
  parameter int unsigned SLOT_W    = 20,
  parameter int unsigned SIDX_W    = 4,
  parameter int unsigned PCM_FIRST = 3,
  parameter int unsigned N_PCM     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slot_end_i,
  input  logic [SIDX_W-1:0] slot_idx_i,
  input  logic [SLOT_W-1:0] word_i,
  input  logic              fv_i,
  input  logic [N_PCM-1:0]  valid_i,
  output logic [N_PCM-1:0]  stb_o,
  output logic [SLOT_W-1:0] data_o
);
  logic [N_PCM-1:0] hit;

  for (genvar i = 0; i < N_PCM; i++) begin : g_slot
    // valid_i is ordered MSB-first: its top bit belongs to the first playback slot
    assign hit[i] = slot_end_i & fv_i & valid_i[N_PCM-1-i]
                  & (slot_idx_i == SIDX_W'(PCM_FIRST + i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_o  <= '0;
      data_o <= '0;
    end else begin
      stb_o <= hit;
      if (|hit) data_o <= word_i;
    end
  end
endmodule

// File: rtl/ac_link_rx.sv
`timescale 1ns/1ps
module ac_link_rx
  import ac_rx_pkg::*;
#(
  parameter int unsigned TAG_W     = TAG_BITS,
  parameter int unsigned SLOT_W    = SLOT_BITS,
  parameter int unsigned NUM_SLOTS = DATA_SLOTS,
  parameter int unsigned PCM_FIRST = PCM_LO,
  parameter int unsigned PCM_LAST  = PCM_HI,
  parameter int unsigned IDX_W     = IDX_BITS,
  parameter int unsigned DATA_W    = WDAT_BITS,
  parameter int unsigned ID_W      = ID_BITS,
  localparam int unsigned N_PCM    = PCM_LAST - PCM_FIRST + 1,
  localparam int unsigned SIDX_W   = $clog2(NUM_SLOTS + 1),
  localparam int unsigned TAGH_W   = PCM_FIRST + N_PCM
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              sdo_i,
  input  logic              ready_i,
  input  logic [ID_W-1:0]   codec_id_i,
  output logic              reg_req_o,
  output logic              reg_wr_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic [N_PCM-1:0]  pcm_stb_o,
  output logic [SLOT_W-1:0] pcm_data_o
);
  logic              slot_end;
  logic [SIDX_W-1:0] slot_idx;
  logic [SLOT_W-1:0] word;
  logic [TAGH_W-1:0] tag_hi_q;
  logic [ID_W-1:0]   tag_id_q;

  ac_rx_timer #(.TAG_W(TAG_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) i_timer (
    .clk_i, .rst_ni, .sync_i,
    .slot_end_o(slot_end), .slot_idx_o(slot_idx)
  );

  ac_rx_shift #(.SLOT_W(SLOT_W)) i_shift (
    .clk_i, .rst_ni, .sdo_i, .word_o(word)
  );

  // tag flags: frame valid, command slots, then playback slots; ID at the bottom
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_hi_q <= '0;
      tag_id_q <= '0;
    end else if (slot_end && slot_idx == '0) begin
      tag_hi_q <= word[TAG_W-1 -: TAGH_W];
      tag_id_q <= word[ID_W-1:0];
    end
  end

  ac_rx_cmd #(.SIDX_W(SIDX_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .ID_W(ID_W)) i_cmd (
    .clk_i, .rst_ni,
    .slot_end_i(slot_end), .slot_idx_i(slot_idx),
    .word_hi_i(word[SLOT_W-1 -: DATA_W]),
    .tag_flags_i(tag_hi_q[TAGH_W-1 -: 3]), .tag_id_i(tag_id_q),
    .codec_id_i, .ready_i,
    .req_o(reg_req_o), .wr_o(reg_wr_o), .idx_o(reg_idx_o), .wdata_o(reg_wdata_o)
  );

  ac_rx_pcm #(.SLOT_W(SLOT_W), .SIDX_W(SIDX_W), .PCM_FIRST(PCM_FIRST), .N_PCM(N_PCM)) i_pcm (
    .clk_i, .rst_ni,
    .slot_end_i(slot_end), .slot_idx_i(slot_idx), .word_i(word),
    .fv_i(tag_hi_q[TAGH_W-1]), .valid_i(tag_hi_q[N_PCM-1:0]),
    .stb_o(pcm_stb_o), .data_o(pcm_data_o)
  );
endmodule

// File: rtl/ac_link_rx_chk.sv
`timescale 1ns/1ps
module ac_link_rx_chk #(
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned N_PCM  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_i,
  input logic              reg_req_o,
  input logic              reg_wr_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic [DATA_W-1:0] reg_wdata_o,
  input logic [N_PCM-1:0]  pcm_stb_o
);
  assert_req_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |=> !reg_req_o);

  assert_wdata_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_req_o && reg_wr_o) |-> $stable(reg_wdata_o));

  assert_even_idx_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> !reg_idx_o[0]);

  assert_ready_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> $past(ready_i));

  assert_pcm_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pcm_stb_o));

  assert_pcm_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|pcm_stb_o) |=> (pcm_stb_o == '0));

  assert_no_overlap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (pcm_stb_o == '0));
endmodule

bind ac_link_rx ac_link_rx_chk #(.IDX_W(IDX_W), .DATA_W(DATA_W), .N_PCM(N_PCM)) i_chk (.*);

// File: tb/test_ac_link_rx.sv
`timescale 1ns/1ps
module test_ac_link_rx;
  logic        clk_i = 1'b0, rst_ni = 1'b0, sync_i = 1'b0, sdo_i = 1'b0, ready_i = 1'b1;
  logic [1:0]  codec_id_i = 2'd0;
  logic        reg_req_o, reg_wr_o;
  logic [6:0]  reg_idx_o;
  logic [15:0] reg_wdata_o;
  logic [7:0]  pcm_stb_o;
  logic [19:0] pcm_data_o;

  ac_link_rx i_ac_link_rx (.*);

  always #2.5 clk_i = ~clk_i;

  int    n_vec = 0, n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R2";
  logic  prev_lsb = 1'b0;
  logic [15:0] tag_w;
  logic [19:0] slot_w [1:12];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit route(input logic [15:0] t, input logic [1:0] id, input bit is_wr);
    if (id == 2'd0) return is_wr ? (t[14] & t[13]) : t[14];
    return (t[1:0] == id) && !t[14] && !t[13];
  endfunction

  function automatic bit exp_rd();
    return tag_w[15] && ready_i && slot_w[1][19] && !slot_w[1][12] && route(tag_w, codec_id_i, 1'b0);
  endfunction

  function automatic bit exp_wr();
    return tag_w[15] && ready_i && !slot_w[1][19] && !slot_w[1][12] && route(tag_w, codec_id_i, 1'b1);
  endfunction

  function automatic logic [15:0] mk_tag(bit fv, bit v1, bit v2, logic [7:0] pv, logic [1:0] id);
    return {fv, v1, v2, pv, 3'b000, id};
  endfunction

  task automatic check_idle(input string req);
    chk(!reg_req_o && pcm_stb_o == 8'd0, req, {23'd0, reg_req_o, pcm_stb_o}, 32'd0);
  endtask

  task automatic check_bit(input int b);
    bit e;
    if (b == 35) begin
      e = exp_rd();
      chk(reg_req_o == e, cur_req, 32'(reg_req_o), 32'(e));
      if (e) chk(!reg_wr_o && reg_idx_o == slot_w[1][18:12], cur_req,
                 {24'd0, reg_wr_o, reg_idx_o}, {25'd0, slot_w[1][18:12]});
    end else if (b == 55) begin
      e = exp_wr();
      chk(reg_req_o == e, cur_req, 32'(reg_req_o), 32'(e));
      if (e) chk(reg_wr_o && reg_idx_o == slot_w[1][18:12] && reg_wdata_o == slot_w[2][19:4], cur_req,
                 {8'd0, reg_wr_o, reg_idx_o, reg_wdata_o}, {8'd1, 1'b0, slot_w[1][18:12], slot_w[2][19:4]});
    end else if (b >= 75 && (b - 75) % 20 == 0 && (b - 75) / 20 < 8) begin
      int j;
      logic [7:0] es;
      j  = (b - 75) / 20;
      e  = tag_w[15] && tag_w[12-j];
      es = e ? (8'd1 << j) : 8'd0;
      chk(pcm_stb_o == es && !reg_req_o, cur_req, 32'(pcm_stb_o), 32'(es));
      if (e) chk(pcm_data_o == slot_w[3+j], cur_req, 32'(pcm_data_o), 32'(slot_w[3+j]));
    end else begin
      check_idle("R2");
    end
  endtask

  task automatic run_frame();
    logic [255:0] fv;
    fv = {tag_w, slot_w[1], slot_w[2], slot_w[3], slot_w[4], slot_w[5], slot_w[6],
          slot_w[7], slot_w[8], slot_w[9], slot_w[10], slot_w[11], slot_w[12]};
    @(negedge clk_i);
    check_idle("R2");
    sync_i = 1'b1;
    sdo_i  = prev_lsb;   // last bit of the previous frame rides the sync edge
    for (int p = 0; p < 255; p++) begin
      @(negedge clk_i);
      check_bit(p - 1);
      sdo_i  = fv[255-p];
      sync_i = (p < 15);
    end
    prev_lsb = fv[0];
  endtask

  task automatic abort_frame(input int n);
    @(negedge clk_i);
    check_idle("R2");
    sync_i = 1'b1;
    sdo_i  = prev_lsb;
    for (int p = 0; p < n; p++) begin
      @(negedge clk_i);
      sdo_i  = 1'($urandom);
      sync_i = (p < 15);
    end
    prev_lsb = 1'($urandom);
  endtask

  task automatic fill_slots();
    for (int k = 1; k <= 12; k++) slot_w[k] = 20'($urandom);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    // R1: state during and after reset
    chk(!reg_req_o && !reg_wr_o && reg_idx_o == 0 && reg_wdata_o == 0 && pcm_stb_o == 0 && pcm_data_o == 0,
        "R1", {7'd0, reg_req_o, reg_wr_o, reg_idx_o, pcm_stb_o, 8'd0}, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(!reg_req_o && reg_wdata_o == 0 && pcm_stb_o == 0 && pcm_data_o == 0, "R1",
        {23'd0, reg_req_o, pcm_stb_o}, 32'd0);

    // R3 primary read
    cur_req = "R3"; fill_slots();
    slot_w[1] = {1'b1, 7'h26, 12'h000}; tag_w = mk_tag(1, 1, 0, 8'h00, 2'd0);
    run_frame();

    // R4 primary write, with playback slots valid
    cur_req = "R4"; fill_slots();
    slot_w[1] = {1'b0, 7'h02, 12'h000}; slot_w[2] = {16'hA5C3, 4'h0};
    tag_w = mk_tag(1, 1, 1, 8'hFF, 2'd0);
    run_frame();
    // R4 write without slot 2 valid must not issue
    fill_slots(); slot_w[1] = {1'b0, 7'h04, 12'h000};
    tag_w = mk_tag(1, 1, 0, 8'h00, 2'd0);
    run_frame();

    // R6 odd index
    cur_req = "R6"; fill_slots();
    slot_w[1] = {1'b1, 7'h27, 12'h000}; tag_w = mk_tag(1, 1, 1, 8'h00, 2'd0);
    run_frame();
    slot_w[1] = {1'b0, 7'h11, 12'h000};
    run_frame();

    // R7 frame valid clear, then ready low
    cur_req = "R7"; fill_slots();
    slot_w[1] = {1'b1, 7'h10, 12'h000}; tag_w = mk_tag(0, 1, 1, 8'hFF, 2'd0);
    run_frame();
    tag_w = mk_tag(1, 1, 1, 8'h00, 2'd0); ready_i = 1'b0;
    run_frame();
    ready_i = 1'b1;

    // R5 secondary codec
    cur_req = "R5"; codec_id_i = 2'd2; fill_slots();
    slot_w[1] = {1'b1, 7'h3C, 12'h000}; tag_w = mk_tag(1, 0, 0, 8'h00, 2'd2);
    run_frame();
    tag_w = mk_tag(1, 0, 0, 8'h00, 2'd1);
    run_frame();
    tag_w = mk_tag(1, 1, 0, 8'h00, 2'd2);
    run_frame();
    slot_w[1] = {1'b0, 7'h1E, 12'h000}; slot_w[2] = {16'h0F0F, 4'h0};
    tag_w = mk_tag(1, 0, 0, 8'h00, 2'd2);
    run_frame();
    codec_id_i = 2'd0;

    // R8 / R9 playback patterns
    cur_req = "R8/R9"; fill_slots();
    tag_w = mk_tag(1, 0, 0, 8'hA5, 2'd0); run_frame();
    fill_slots(); tag_w = mk_tag(1, 0, 0, 8'h5A, 2'd0); run_frame();
    fill_slots(); tag_w = mk_tag(1, 0, 0, 8'h81, 2'd0); run_frame();

    // R10 realign after a sync in mid frame
    cur_req = "R10"; abort_frame(45);
    fill_slots(); slot_w[1] = {1'b1, 7'h5A, 12'h000};
    tag_w = mk_tag(1, 1, 1, 8'h40, 2'd0);
    run_frame();
    abort_frame(130);
    fill_slots(); slot_w[1] = {1'b0, 7'h08, 12'h000};
    tag_w = mk_tag(1, 1, 1, 8'h01, 2'd0);
    run_frame();

    // random frames
    cur_req = "R3/R4/R5/R8 random";
    for (int f = 0; f < 40; f++) begin
      logic [1:0] id;
      fill_slots();
      id = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
      codec_id_i = id;
      ready_i = ($urandom % 8) != 0;
      tag_w = 16'($urandom);
      if ($urandom % 4 != 0) tag_w[15] = 1'b1;
      if (id != 0 && $urandom % 2 == 1) begin tag_w[14:13] = 2'b00; tag_w[1:0] = id; end
      if ($urandom % 4 != 0) slot_w[1][12] = 1'b0;
      run_frame();
    end
    ready_i = 1'b1; codec_id_i = 2'd0;

    @(negedge clk_i);
    check_idle("R2");
    sync_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check_idle("R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule